// File: doc/BRIEF.md
# Fractional-Mantissa Floating-Point Adder/Subtractor

This block adds or subtracts two numbers held in a compact floating-point word. Each word has a sign bit, a two's-complement exponent and an unsigned mantissa read as a binary fraction. A normalized mantissa has its top bit set, so its value lies in [0.5, 1.0). A word whose mantissa is all zeros is zero, whatever its sign and exponent are. The operand with the larger magnitude sets the working exponent. The other operand's mantissa is shifted right by the exponent gap, and the two are added or subtracted according to the signs and the requested operation.

The raw result is then renormalized. A carry out of the top bit is removed with a one-bit right shift. A cancellation is removed by shifting left by the leading-zero count. In both cases the exponent is corrected to match. The final exponent is then checked against the format's range. A result that is too large saturates and raises an overflow flag. A result that is exactly zero, or too small to represent, becomes canonical zero and raises a zero flag. The pipeline is three registers deep and accepts one operation per clock.

Top module: `fp_frac_adder`

## Requirements
- R1: An operation presented with `in_valid` high is sampled at a rising edge, and its result appears with `out_valid` high just after the second rising edge that follows. A new operation can be accepted on every cycle, and `out_valid` is low when no operation was presented three edges earlier.
- R2: Word layout, from most significant bit down: sign (1 means negative), exponent of EW bits in two's complement, mantissa of MW bits with value mantissa/2^MW. The mantissa of the operand with the smaller magnitude is shifted right by the exponent difference, and the bits shifted out are discarded.
- R3: Operand b is negated when `op_sub` is 1. When the two effective signs differ, the smaller aligned magnitude is subtracted from the larger one. Otherwise the two are added.
- R4: When the mantissa sum reaches 1.0 or more, it is shifted right by one bit (the low bit is dropped) and the exponent is increased by one.
- R5: When a subtraction leaves a non-zero mantissa below 0.5, the mantissa is shifted left by its leading-zero count and the exponent is reduced by that count. Every non-zero result has its mantissa top bit set.
- R6: When the exponent difference is MW or more, the smaller operand contributes nothing and the larger operand's magnitude passes through unchanged.
- R7: The result takes the effective sign of the operand with the larger magnitude. An exact cancellation gives the all-zero word with `zero` high.
- R8: When the corrected exponent exceeds 2^(EW-1)-1, the result saturates to that exponent with an all-ones mantissa, keeps its sign, and raises `ovf`.
- R9: When the corrected exponent falls below -2^(EW-1), the result is the all-zero word with `zero` high and `ovf` low.
- R10: While `rst_n` is low, `out_valid`, `ovf` and `zero` are low.
- R11: An operand whose mantissa is all zeros counts as zero regardless of its sign and exponent. Adding it leaves the other operand's value unchanged, apart from the sign flip that subtraction applies to b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on a, b and op_sub |
| op_sub | input | 1 | 1 computes a - b, 0 computes a + b |
| a | input | 1+EW+MW | First operand |
| b | input | 1+EW+MW | Second operand |
| out_valid | output | 1 | Result word and flags are valid |
| result | output | 1+EW+MW | Sum or difference |
| ovf | output | 1 | Exponent overflow; result saturated |
| zero | output | 1 | Result is zero (exact or underflowed) |

## Verification
The assertions assume that every operand presented with `in_valid` high is either normalized, with its mantissa top bit set, or a zero with an all-zero mantissa. The normalization and saturation checks on the output hold only under that assumption, and a separate input assertion guards it. The stimulus is built only from such words. With a 3-bit exponent and a 4-bit mantissa, it pairs every normalized value and every zero encoding, under both operations. Idle cycles are inserted at intervals so that the valid pipeline is exercised with gaps as well as back to back.

// File: rtl/fp_frac_adder.sv
module fp_frac_adder #(
  parameter int EW = 8,
  parameter int MW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [EW+MW:0]    a,
  input  logic [EW+MW:0]    b,
  output logic              out_valid,
  output logic [EW+MW:0]    result,
  output logic              ovf,
  output logic              zero
);
  localparam int W    = 1 + EW + MW;
  localparam int CW   = $clog2(MW + 1);
  localparam int XW   = EW + CW + 1;
  localparam int EMAX = (1 << (EW - 1)) - 1;
  localparam int EMIN = -(1 << (EW - 1));
  localparam logic signed [XW-1:0] XMAX = XW'(EMAX);
  localparam logic signed [XW-1:0] XMIN = XW'(EMIN);

  logic                 sa, sb_eff, za, zb, a_big;
  logic signed [EW-1:0] ea, eb;
  logic [MW-1:0]        ma, mb;

  assign sa     = a[W-1];
  assign sb_eff = b[W-1] ^ op_sub;
  assign ea     = a[W-2:MW];
  assign eb     = b[W-2:MW];
  assign ma     = a[MW-1:0];
  assign mb     = b[MW-1:0];
  assign za     = (ma == '0);
  assign zb     = (mb == '0);
  assign a_big  = zb || (!za && (ea > eb || (ea == eb && ma >= mb)));

  // stage 1: swap and align
  logic                 s1_sign, s1_sub;
  logic signed [EW-1:0] s1_exp;
  logic [MW-1:0]        s1_ml, s1_ms;
  logic                 c1_sign, c1_sub;
  logic signed [EW-1:0] c1_exp;
  logic [MW-1:0]        c1_ml, c1_ms;

  always_comb begin
    logic signed [EW-1:0] e_small;
    logic [MW-1:0]        m_small;
    int                   gap;
    c1_exp  = a_big ? ea : eb;
    e_small = a_big ? eb : ea;
    c1_ml   = a_big ? ma : mb;
    m_small = a_big ? mb : ma;
    c1_sign = a_big ? sa : sb_eff;
    c1_sub  = sa ^ sb_eff;
    gap     = int'(c1_exp) - int'(e_small);
    if (m_small == '0 || gap < 0 || gap >= MW) c1_ms = '0;
    else                                       c1_ms = m_small >> gap;
  end

  // stage 2: add or subtract magnitudes
  logic                 s2_sign;
  logic signed [EW-1:0] s2_exp;
  logic [MW:0]          s2_sum;
  logic [MW:0]          c2_sum;

  assign c2_sum = s1_sub ? ({1'b0, s1_ml} - {1'b0, s1_ms})
                         : ({1'b0, s1_ml} + {1'b0, s1_ms});

  // stage 3: renormalize and range check
  function automatic logic [CW-1:0] lead_zeros(input logic [MW-1:0] x);
    lead_zeros = CW'(MW);
    for (int i = 0; i < MW; i++)
      if (x[i]) lead_zeros = CW'(MW - 1 - i);
  endfunction

  logic [CW-1:0]        lz;
  logic signed [XW-1:0] e_ext, e_new;
  logic [MW-1:0]        m_new;
  logic [W-1:0]         c3_res;
  logic                 c3_ovf, c3_zero;

  assign lz    = lead_zeros(s2_sum[MW-1:0]);
  assign e_ext = XW'(s2_exp);

  always_comb begin
    if (s2_sum[MW]) begin
      e_new = e_ext + XW'(1);
      m_new = s2_sum[MW:1];
    end else begin
      e_new = e_ext - $signed({1'b0, XW'(lz)});
      m_new = s2_sum[MW-1:0] << lz;
    end
    c3_ovf  = 1'b0;
    c3_zero = 1'b0;
    c3_res  = {s2_sign, e_new[EW-1:0], m_new};
    if (s2_sum == '0 || e_new < XMIN) begin
      c3_zero = 1'b1;
      c3_res  = '0;
    end else if (e_new > XMAX) begin
      c3_ovf  = 1'b1;
      c3_res  = {s2_sign, EW'(EMAX), {MW{1'b1}}};
    end
  end

  logic v1, v2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
      s1_sign <= 1'b0; s1_sub <= 1'b0; s1_exp <= '0; s1_ml <= '0; s1_ms <= '0;
      s2_sign <= 1'b0; s2_exp <= '0; s2_sum <= '0;
      result <= '0; ovf <= 1'b0; zero <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
      s1_sign <= c1_sign; s1_sub <= c1_sub; s1_exp <= c1_exp;
      s1_ml <= c1_ml; s1_ms <= c1_ms;
      s2_sign <= s1_sign; s2_exp <= s1_exp; s2_sum <= c2_sum;
      result <= c3_res; ovf <= c3_ovf; zero <= c3_zero;
    end
  end

  p_in_norm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (a[MW-1] || a[MW-1:0] == '0) && (b[MW-1] || b[MW-1:0] == '0));
  p_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);
  p_norm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !zero) |-> result[MW-1]);
  p_zero_canon_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zero) |-> (result == '0 && !ovf));
  p_ovf_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf) |-> (result[W-2:0] == {EW'(EMAX), {MW{1'b1}}}));
endmodule

// File: tb/test_fp_frac_adder.sv
`timescale 1ns/1ps
module test_fp_frac_adder;
  localparam int EW = 3, MW = 4, W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, in_valid = 1'b0, op_sub = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic out_valid, ovf, zero;
  logic [W-1:0] result;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  fp_frac_adder #(.EW(EW), .MW(MW)) i_fp_frac_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .a(a), .b(b), .out_valid(out_valid), .result(result), .ovf(ovf), .zero(zero));

  logic         hv[3];
  logic [W+1:0] hx[3];
  string        ht[3];

  function automatic logic [W+1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic sub, output string tag);
    int ex = $signed(x[6:4]), ey = $signed(y[6:4]);
    int mx = x[3:0], my = y[3:0];
    int sx = x[7], sy = y[7] ^ sub;
    int vx = mx << (ex + 4), vy = my << (ey + 4);
    int eL, eS, mL, mS, sL, sS, d, s, r, e;
    logic carry = 0, lsh = 0;
    if (vx >= vy) begin eL = ex; mL = mx; sL = sx; eS = ey; mS = my; sS = sy; end
    else          begin eL = ey; mL = my; sL = sy; eS = ex; mS = mx; sS = sx; end
    d = eL - eS;
    s = (mS == 0 || d >= MW) ? 0 : (mS >> d);
    r = (sL != sS) ? mL - s : mL + s;
    e = eL;
    if (r == 0) begin tag = "R7"; return {2'b01, 8'h00}; end
    while (r >= 16) begin r = r >> 1; e++; carry = 1; end
    while (r < 8)   begin r = r << 1; e--; lsh = 1; end
    if (e < -4) begin tag = "R9"; return {2'b01, 8'h00}; end
    if (e > 3)  begin tag = "R8"; return {2'b10, sL[0], 3'd3, 4'hF}; end
    if (mx == 0 || my == 0) tag = "R11";
    else if (mS != 0 && d >= MW) tag = "R6";
    else if (carry) tag = "R4";
    else if (lsh) tag = "R5";
    else if (sL != sS) tag = "R3 R7";
    else tag = "R2";
    return {2'b00, sL[0], 3'(e), 4'(r)};
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== hv[2]) begin
      errors++;
      $display("FAIL R1 out_valid actual %b expected %b", out_valid, hv[2]);
    end
    if (hv[2]) begin
      checks++;
      if ({ovf, zero, result} !== hx[2]) begin
        errors++;
        $display("FAIL %s {ovf,zero,result} actual %b expected %b", ht[2], {ovf, zero, result}, hx[2]);
      end
    end
  endtask

  task automatic step(input logic v, input logic sub, input logic [W-1:0] x, input logic [W-1:0] y);
    string t;
    logic [W+1:0] e;
    @(negedge clk);
    check_out();
    e = model(x, y, sub, t);
    hv[2] = hv[1]; hx[2] = hx[1]; ht[2] = ht[1];
    hv[1] = hv[0]; hx[1] = hx[0]; ht[1] = ht[0];
    hv[0] = v; hx[0] = e; ht[0] = t;
    in_valid = v; op_sub = sub; a = x; b = y;
  endtask

  function automatic logic [W-1:0] word(input int i);
    int code = i / 16;
    logic [3:0] m = (code == 0) ? 4'd0 : 4'(7 + code);
    return {i[0], 3'((i >> 1) % 8), m};
  endfunction

  initial begin
    int n = 0;
    for (int k = 0; k < 3; k++) begin hv[k] = 1'b0; hx[k] = '0; ht[k] = "R1"; end
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || ovf !== 1'b0 || zero !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset outputs actual %b%b%b expected 000", out_valid, ovf, zero);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 144; i++)
      for (int j = 0; j < 144; j++)
        for (int op = 0; op < 2; op++) begin
          step(1'b1, op[0], word(i), word(j));
          n++;
          if (n % 13 == 5) step(1'b0, 1'b0, '0, '0);
        end
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule